// File: doc/BRIEF.md
# Floppy Byte-Transfer Wait-State Controller

This block lets an 8-bit processor move floppy disk data one byte per I/O instruction without a DMA engine. The processor reads or writes any port whose upper address nibble is 2. The block then pulls the processor's READY line low, which holds the bus cycle in wait states, and it raises the disk controller's DMA acknowledge. The stall ends when the disk controller raises its data request. At that point the pending bus cycle completes and carries the byte.

A disk controller interrupt during the stall also ends it. This way an execution phase that stops on an error does not leave the processor hung. The block records that kind of release in a sticky status flag, because the level interrupt line goes away as soon as software reads the first result byte. An enable bit in a small control port turns the mechanism on and off. While it is clear, the transfer window behaves like ordinary ports with no wait states.

READY and DACK are registered. The processor is expected to sample READY no earlier than one clock after it asserts its I/O strobe, and it keeps the strobe asserted until READY is seen high.

Top module: `pdma_wait_ctrl`

## Requirements
- R1: With the enable bit set, an I/O read or write to a port in 20H–2FH (address bits 7:4 equal to 2) seen while idle drives READY low from the next clock edge.
- R2: DACK goes high on the same clock edge that READY drops, and it stays high for the whole stall.
- R3: While stalled, DRQ high returns READY high at the next clock edge. DACK is still high in that cycle.
- R4: There is no timeout. With neither DRQ nor INT high, READY stays low indefinitely (checked over 10,000 clocks).
- R5: INT high while stalled releases READY at the next clock edge, just as DRQ does. If DRQ and INT are high together, the release counts as a data release.
- R6: DACK drops one clock after READY returns high. It stays low until the next transfer access begins, even while the same strobe is still held.
- R7: A release by INT without DRQ sets a status flag. A read of port 31H returns the flag on data bit 0 with bits 7:1 zero, and the read data bus is zero whenever port 31H is not being read.
- R8: The status flag clears on the clock edge after a read of port 31H ends, or when a new transfer access begins.
- R9: A write to port 30H loads the enable bit from data bit 0. When the bit is clear, accesses to 20H–2FH leave READY high and DACK low.
- R10: Accesses outside 20H–2FH, and DRQ or INT pulses while no transfer access is pending, change neither READY, DACK nor the status flag.
- R11: After reset, READY is high, DACK is low, the enable bit is clear, the status flag is clear and the read data bus is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 8 | I/O port address |
| io_rd | input | 1 | I/O read strobe, held for the whole bus cycle |
| io_wr | input | 1 | I/O write strobe, held for the whole bus cycle |
| cpu_wdata | input | 8 | Processor write data, used by the control port |
| cpu_rdata | output | 8 | Status read data, zero outside a status port read |
| cpu_ready | output | 1 | Processor READY, low holds the bus cycle in wait states |
| fdc_drq | input | 1 | Disk controller data request |
| fdc_int | input | 1 | Disk controller interrupt, level |
| fdc_dack | output | 1 | DMA acknowledge to the disk controller |

## Verification
The bench stalls the processor for varying lengths and releases each stall by DRQ, by INT or by both at once.

- **Wrong release priority.** If the logic ranked INT above DRQ, a simultaneous release would wrongly set the status flag.
- **Premature release.** A hidden timeout would let READY rise during the 10,000-clock stall.
- **DACK cleared too early or retriggered.** If DACK dropped together with READY, or rose again while the strobe is still held after release, the per-cycle DACK checks catch it.
- **Flag clearing.** The flag is cleared both ways, by a status read and by a new transfer access. A flag that is never cleared, or one that an idle interrupt pulse can set, shows up in the status reads that follow.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HOLD   = 2'd1,
        ST_DRAIN  = 2'd2,
        ST_FINISH = 2'd3
    } xfer_state_e;

    typedef struct packed {
        xfer_state_e st;
        logic        ready;
        logic        dack;
    } fsm_regs_t;

    typedef struct packed {
        logic en;
        logic flag;
        logic rd_prev;
    } ctl_regs_t;

endpackage

// File: rtl/pdma_decode.sv
module pdma_decode #(
    parameter int          ADDR_W    = 8,
    parameter int          WIN_W     = 4,
    parameter logic [3:0]  WIN_HI    = 4'h2,
    parameter logic [7:0]  CTRL_PORT = 8'h30,
    parameter logic [7:0]  STAT_PORT = 8'h31
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              io_rd_i,
    input  logic              io_wr_i,
    output logic              strobe_o,
    output logic              win_hit_o,
    output logic              ctrl_wr_o,
    output logic              stat_rd_o
);

    localparam int LO = ADDR_W - WIN_W;

    logic [WIN_W-1:0] upper;
    logic             in_window;

    always_comb begin
        upper     = addr_i[ADDR_W-1:LO];
        in_window = (upper == WIN_HI[WIN_W-1:0]);
        strobe_o  = io_rd_i | io_wr_i;
        win_hit_o = strobe_o & in_window;
        ctrl_wr_o = io_wr_i & (addr_i == ADDR_W'(CTRL_PORT));
        stat_rd_o = io_rd_i & (addr_i == ADDR_W'(STAT_PORT));
    end

endmodule

// File: rtl/pdma_hold_fsm.sv
module pdma_hold_fsm
    import pdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic strobe_i,
    input  logic win_hit_i,
    input  logic drq_i,
    input  logic intr_i,
    output logic ready_o,
    output logic dack_o,
    output logic start_o,
    output logic int_rel_o
);

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        start_o   = 1'b0;
        int_rel_o = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (win_hit_i && en_i) begin
                    start_o  = 1'b1;
                    r_d.st    = ST_HOLD;
                    r_d.ready = 1'b0;
                    r_d.dack  = 1'b1;
                end
            end
            ST_HOLD: begin
                // DRQ wins over INT: a simultaneous release carries data
                if (drq_i || intr_i) begin
                    int_rel_o = intr_i & ~drq_i;
                    r_d.st    = ST_DRAIN;
                    r_d.ready = 1'b1;
                end
            end
            ST_DRAIN: begin
                r_d.dack = 1'b0;
                r_d.st   = strobe_i ? ST_FINISH : ST_IDLE;
            end
            ST_FINISH: begin
                if (!strobe_i) r_d.st = ST_IDLE;
            end
            default: r_d = '{st: ST_IDLE, ready: 1'b1, dack: 1'b0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, ready: 1'b1, dack: 1'b0};
        else        r_q <= r_d;
    end

    assign ready_o = r_q.ready;
    assign dack_o  = r_q.dack;

    p_stall_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && win_hit_i && en_i) |=> (!ready_o && dack_o));
    p_dack_in_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o) |-> dack_o);
    p_drq_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HOLD && drq_i) |=> (ready_o && dack_o));
    p_no_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HOLD && !drq_i && !intr_i) |=> !ready_o);
    p_int_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HOLD && intr_i) |=> ready_o);
    p_dack_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |=> !dack_o);
    p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && !en_i) |=> (ready_o && !dack_o));

endmodule

// File: rtl/pdma_ctl_regs.sv
module pdma_ctl_regs
    import pdma_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int EN_BIT   = 0,
    parameter int FLAG_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              stat_rd_i,
    input  logic              set_flag_i,
    input  logic              clr_start_i,
    output logic              en_o,
    output logic [DATA_W-1:0] rdata_o
);

    ctl_regs_t c_d, c_q;
    logic      rd_end;

    always_comb begin
        c_d         = c_q;
        rd_end      = c_q.rd_prev & ~stat_rd_i;
        c_d.rd_prev = stat_rd_i;
        if (ctrl_wr_i) c_d.en = wdata_i[EN_BIT];
        if (set_flag_i)                  c_d.flag = 1'b1;
        else if (rd_end || clr_start_i)  c_d.flag = 1'b0;
        rdata_o = '0;
        if (stat_rd_i) rdata_o[FLAG_BIT] = c_q.flag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{en: 1'b0, flag: 1'b0, rd_prev: 1'b0};
        else        c_q <= c_d;
    end

    assign en_o = c_q.en;

    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_flag_i |=> c_q.flag);
    p_flag_clr_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.rd_prev && !stat_rd_i && !set_flag_i) |=> !c_q.flag);
    p_flag_clr_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_start_i && !set_flag_i) |=> !c_q.flag);
    p_enable_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr_i |=> (en_o == $past(wdata_i[EN_BIT])));

endmodule

// File: rtl/pdma_wait_ctrl.sv
module pdma_wait_ctrl #(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 8,
    parameter logic [3:0]  WIN_HI    = 4'h2,
    parameter logic [7:0]  CTRL_PORT = 8'h30,
    parameter logic [7:0]  STAT_PORT = 8'h31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    input  logic              fdc_drq,
    input  logic              fdc_int,
    output logic              fdc_dack
);

    localparam int WIN_W = 4;

    logic strobe, win_hit, ctrl_wr, stat_rd;
    logic en, start, int_rel;

    pdma_decode #(
        .ADDR_W(ADDR_W), .WIN_W(WIN_W), .WIN_HI(WIN_HI),
        .CTRL_PORT(CTRL_PORT), .STAT_PORT(STAT_PORT)
    ) u_decode (
        .addr_i(cpu_addr), .io_rd_i(io_rd), .io_wr_i(io_wr),
        .strobe_o(strobe), .win_hit_o(win_hit),
        .ctrl_wr_o(ctrl_wr), .stat_rd_o(stat_rd)
    );

    pdma_hold_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en_i(en), .strobe_i(strobe),
        .win_hit_i(win_hit), .drq_i(fdc_drq), .intr_i(fdc_int),
        .ready_o(cpu_ready), .dack_o(fdc_dack),
        .start_o(start), .int_rel_o(int_rel)
    );

    pdma_ctl_regs #(.DATA_W(DATA_W), .EN_BIT(0), .FLAG_BIT(0)) u_regs (
        .clk(clk), .rst_n(rst_n), .ctrl_wr_i(ctrl_wr), .wdata_i(cpu_wdata),
        .stat_rd_i(stat_rd), .set_flag_i(int_rel), .clr_start_i(start),
        .en_o(en), .rdata_o(cpu_rdata)
    );

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && !fdc_dack && !win_hit) |=> (cpu_ready && !fdc_dack));

endmodule

// File: tb/pdma_wait_ctrl_tb_top.sv
module pdma_wait_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cpu_addr = 8'h00;
    logic       io_rd = 1'b0, io_wr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       cpu_ready, fdc_dack;
    logic       fdc_drq = 1'b0, fdc_int = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    pdma_wait_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .io_rd(io_rd),
        .io_wr(io_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .fdc_drq(fdc_drq), .fdc_int(fdc_int),
        .fdc_dack(fdc_dack)
    );

    // kind: 0 = DRQ release, 1 = INT release, 2 = both together
    typedef struct packed {
        logic [7:0] addr;
        logic       wr;
        logic [1:0] kind;
        logic [7:0] hold;
        logic       flag;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{8'h20, 1'b0, 2'd0, 8'd3,  1'b0},
        '{8'h2F, 1'b1, 2'd1, 8'd0,  1'b1},
        '{8'h27, 1'b0, 2'd2, 8'd5,  1'b0},
        '{8'h2A, 1'b1, 2'd0, 8'd12, 1'b0},
        '{8'h23, 1'b0, 2'd1, 8'd7,  1'b1},
        '{8'h2C, 1'b1, 2'd2, 8'd1,  1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic write_port(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); cpu_addr = a; cpu_wdata = d; io_wr = 1'b1;
        tick();
        @(negedge clk); io_wr = 1'b0;
        tick();
    endtask

    task automatic read_status(input logic exp, input string tag);
        @(negedge clk); cpu_addr = 8'h31; io_rd = 1'b1;
        tick();
        chk(tag, cpu_rdata, {7'b0, exp});
        @(negedge clk); io_rd = 1'b0;
        tick();
    endtask

    task automatic xfer(input logic [7:0] a, input logic wr, input logic [1:0] kind,
                        input int hold);
        @(negedge clk); cpu_addr = a; io_rd = ~wr; io_wr = wr;
        tick();
        chk("R1 ready low", cpu_ready, 0);
        chk("R2 dack high", fdc_dack, 1);
        repeat (hold) tick();
        chk("R2 dack held", fdc_dack, 1);
        @(negedge clk);
        fdc_drq = (kind != 2'd1);
        fdc_int = (kind != 2'd0);
        tick();
        chk(kind == 2'd0 ? "R3 drq release" : "R5 int release", cpu_ready, 1);
        chk("R3 dack at release", fdc_dack, 1);
        @(negedge clk); fdc_drq = 1'b0; fdc_int = 1'b0;
        tick();
        chk("R6 dack drop", fdc_dack, 0);
        tick();
        chk("R6 no retrigger", {cpu_ready, fdc_dack}, 2'b10);
        @(negedge clk); io_rd = 1'b0; io_wr = 1'b0;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R11 ready", cpu_ready, 1);
        chk("R11 dack", fdc_dack, 0);
        chk("R11 rdata", cpu_rdata, 0);
        @(negedge clk); rst_n = 1'b1;
        tick();

        // R11/R9: enable clear after reset, window access takes no wait
        @(negedge clk); cpu_addr = 8'h25; io_rd = 1'b1;
        tick(); tick();
        chk("R11 enable clear", {cpu_ready, fdc_dack}, 2'b10);
        @(negedge clk); io_rd = 1'b0;
        tick();
        read_status(1'b0, "R11 flag clear");

        write_port(8'h30, 8'h01);

        foreach (VECS[i]) begin
            xfer(VECS[i].addr, VECS[i].wr, VECS[i].kind, int'(VECS[i].hold));
            read_status(VECS[i].flag, "R7 status flag");
            read_status(1'b0, "R8 cleared by read");
        end

        // R10: outside window, and idle DRQ/INT pulses
        @(negedge clk); cpu_addr = 8'h35; io_rd = 1'b1;
        tick();
        chk("R10 outside window", {cpu_ready, fdc_dack}, 2'b10);
        chk("R7 rdata zero off status port", cpu_rdata, 0);
        @(negedge clk); io_rd = 1'b0; fdc_drq = 1'b1; fdc_int = 1'b1;
        tick(); tick();
        chk("R10 idle drq/int", {cpu_ready, fdc_dack}, 2'b10);
        @(negedge clk); fdc_drq = 1'b0; fdc_int = 1'b0;
        tick();
        read_status(1'b0, "R10 idle int no flag");

        // R4: long stall, no timeout
        begin
            int bad = 0;
            @(negedge clk); cpu_addr = 8'h21; io_rd = 1'b1;
            repeat (10000) begin
                tick();
                if (cpu_ready !== 1'b0 || fdc_dack !== 1'b1) bad++;
            end
            chk("R4 long stall", bad, 0);
            @(negedge clk); fdc_drq = 1'b1;
            tick();
            chk("R3 release after long stall", cpu_ready, 1);
            @(negedge clk); fdc_drq = 1'b0; io_rd = 1'b0;
            tick(); tick();
        end

        // R8: new transfer access clears the flag
        xfer(8'h2B, 1'b0, 2'd1, 2);
        xfer(8'h2B, 1'b1, 2'd0, 2);
        read_status(1'b0, "R8 cleared by new access");

        // R9: disable, window access runs with no wait
        write_port(8'h30, 8'hFE);
        @(negedge clk); cpu_addr = 8'h24; io_wr = 1'b1;
        tick(); tick(); tick();
        chk("R9 disabled no wait", {cpu_ready, fdc_dack}, 2'b10);
        @(negedge clk); io_wr = 1'b0;
        tick();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule